// File: doc/BRIEF.md
# Byte Buffer with Word-Wide Register Access

This block sits between a byte-wide parallel port and a 32-bit register or DMA side. A small circular byte store holds data in flight. In receive mode the port pushes single bytes and software or DMA takes them out four at a time through the data register. The oldest byte comes out in bits 7:0, the next in bits 15:8, then bits 23:16, and the newest in bits 31:24. In transmit mode the direction reverses. A 32-bit write loads four bytes, and the port pulls them out one by one, starting with bits 7:0.

The mode is held by a three-state machine. The states are `ST_OFF` (disabled), `ST_RX` (receive) and `ST_TX` (transmit). The transition `ST_OFF -> ST_RX` happens on a control write with the enable bit set and the direction bit clear. The transition `ST_OFF -> ST_TX` happens on a control write with both the enable bit and the direction bit set. The transitions `ST_RX -> ST_OFF` and `ST_TX -> ST_OFF` happen on a control write with the enable bit clear, and that write flushes the store. Any other control write leaves the state unchanged.

Two ready flags say whether one or four bytes can move. They count stored bytes in receive mode and free bytes in transmit mode. A sticky error flag records an overrun (receive) or an underrun (transmit). An enable bit masks that flag onto the interrupt output.

Top module: `byte_word_fifo`

## Requirements
- R1: After reset the control register reads 0x4: enable (bit 0) is 0, direction (bit 1) is 0 and DMA enable (bit 2) is 1. The status, raw error, interrupt enable and masked registers read 0, and `irq` and `dma_req` are low.
- R2: The data register at offset 0x28 packs bytes oldest-first. Bits 7:0 hold the oldest byte, then bits 15:8, bits 23:16, and bits 31:24 hold the newest. This holds for a receive read and for the port order of a transmit write.
- R3: In receive mode the status register at offset 0x04 has bit 0 set when at least one byte is stored and bit 1 set when at least four bytes are stored. The store holds at most 8 bytes.
- R4: In transmit mode status bit 0 is set when at least one byte is free, and bit 1 is set when at least four bytes are free.
- R5: While disabled both status flags read 0, and port pushes and pulls are ignored. They store nothing and raise no error.
- R6: A control write that clears enable while the block is enabled moves it to `ST_OFF` and discards every stored byte.
- R7: In receive mode a port push into a full store is dropped and sets the raw error flag (offset 0x08, bit 0).
- R8: In transmit mode a port pull from an empty store returns 0 on `port_dout` and sets the raw error flag.
- R9: The raw error flag stays set until a write to offset 0x14 with bit 0 at 1. Writing 0 there has no effect, and offset 0x14 reads 0.
- R10: The masked register (offset 0x10, bit 0) and `irq` equal the raw flag ANDed with the interrupt enable (offset 0x0C, bit 0).
- R11: `dma_req` is high exactly when DMA enable is set, the block is enabled and the four-byte flag is set.
- R12: A control write while enabled changes only the enable bit. Direction and DMA enable keep their values.
- R13: Unmapped offsets read 0. A data read with fewer than four bytes stored returns 0 and removes nothing. A data write with fewer than four bytes free is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a read of the data register consumes bytes |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| port_push | input | 1 | Port delivers a byte (receive) |
| port_din | input | 8 | Byte from the port |
| port_pull | input | 1 | Port takes a byte (transmit) |
| port_dout | output | 8 | Oldest stored byte in transmit mode, else 0 |
| dma_req | output | 1 | Request for a four-byte transfer |
| irq | output | 1 | Masked overrun/underrun interrupt |

## Verification
The bench builds the block with its default parameters: an 8-byte store, 8-bit bytes and four lanes. With only two words of room, both the full and the empty boundary are reached after a handful of port operations. One vector walk covers a full receive pass and a full transmit pass, including overrun at the ninth byte and underrun one pull past empty. Four-lane packing against an 8-deep ring also forces the read and write pointers to wrap.

// File: rtl/byte_word_fifo_pkg.sv
package byte_word_fifo_pkg;
    typedef enum logic [1:0] {
        ST_OFF = 2'd0,
        ST_RX  = 2'd1,
        ST_TX  = 2'd2
    } port_state_t;

    localparam int ADDR_W = 8;
    localparam logic [ADDR_W-1:0] OFF_CTRL = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_STAT = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_RAW  = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_IE   = 8'h0C;
    localparam logic [ADDR_W-1:0] OFF_MIS  = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_CLR  = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_DATA = 8'h28;
endpackage

// File: rtl/byte_ring.sv
// Circular byte store: single-byte or whole-word put and take.
// DEPTH must be a power of two so the pointers wrap naturally.
module byte_ring #(
    parameter int DEPTH  = 8,
    parameter int BYTE_W = 8,
    parameter int LANES  = 4,
    localparam int PW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int WW    = LANES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              put_one,
    input  logic [BYTE_W-1:0] one_in,
    input  logic              put_word,
    input  logic [WW-1:0]     word_in,
    input  logic              take_one,
    input  logic              take_word,
    output logic [CW-1:0]     level,
    output logic [BYTE_W-1:0] head,
    output logic [WW-1:0]     word_out
);
    logic [BYTE_W-1:0] mem [DEPTH];
    logic [PW-1:0]     wr_q, rd_q;
    logic [CW-1:0]     level_q;
    logic [CW-1:0]     in_n, out_n;

    always_comb begin
        in_n  = put_one  ? CW'(1) : (put_word  ? CW'(LANES) : '0);
        out_n = take_one ? CW'(1) : (take_word ? CW'(LANES) : '0);
    end

    always_ff @(posedge clk) begin
        if (put_one) begin
            mem[wr_q] <= one_in;
        end else if (put_word) begin
            for (int i = 0; i < LANES; i++) begin
                mem[wr_q + PW'(i)] <= word_in[i*BYTE_W +: BYTE_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q    <= '0;
            rd_q    <= '0;
            level_q <= '0;
        end else if (flush) begin
            wr_q    <= '0;
            rd_q    <= '0;
            level_q <= '0;
        end else begin
            wr_q    <= wr_q + PW'(in_n);
            rd_q    <= rd_q + PW'(out_n);
            level_q <= level_q + in_n - out_n;
        end
    end

    assign level = level_q;
    assign head  = mem[rd_q];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign word_out[g*BYTE_W +: BYTE_W] = mem[rd_q + PW'(g)];
    end
endmodule

// File: rtl/port_mode_fsm.sv
// Mode state machine: off, receive, transmit. Configuration is held only while off.
module port_mode_fsm
    import byte_word_fifo_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr,
    input  logic        cfg_en,
    input  logic        cfg_dir,
    input  logic        cfg_dma,
    output port_state_t state,
    output logic        dir_q,
    output logic        dma_q,
    output logic        flush
);
    port_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            dir_q   <= 1'b0;
            dma_q   <= 1'b1;
        end else begin
            state_q <= state_d;
            if (cfg_wr && state_q == ST_OFF) begin
                dir_q <= cfg_dir;
                dma_q <= cfg_dma;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        flush   = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                if (cfg_wr && cfg_en) begin
                    state_d = cfg_dir ? ST_TX : ST_RX;
                end
            end
            ST_RX, ST_TX: begin
                if (cfg_wr && !cfg_en) begin
                    state_d = ST_OFF;
                    flush   = 1'b1;
                end
            end
            default: state_d = ST_OFF;
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/err_irq.sv
// Sticky overrun/underrun flag, its enable, and the masked interrupt.
module err_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic err_evt,
    input  logic clr_req,
    input  logic ie_wr,
    input  logic ie_bit,
    output logic raw,
    output logic ie,
    output logic irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw <= 1'b0;
            ie  <= 1'b0;
        end else begin
            if (err_evt)      raw <= 1'b1;
            else if (clr_req) raw <= 1'b0;
            if (ie_wr)        ie  <= ie_bit;
        end
    end

    assign irq = raw & ie;
endmodule

// File: rtl/byte_word_fifo.sv
module byte_word_fifo
    import byte_word_fifo_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int BYTE_W = 8,
    parameter int LANES  = 4,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int WW    = LANES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WW-1:0]     reg_wdata,
    output logic [WW-1:0]     reg_rdata,
    input  logic              port_push,
    input  logic [BYTE_W-1:0] port_din,
    input  logic              port_pull,
    output logic [BYTE_W-1:0] port_dout,
    output logic              dma_req,
    output logic              irq
);
    port_state_t       state;
    logic              dir_q, dma_q, flush;
    logic              in_rx, in_tx;
    logic [CW-1:0]     level, free;
    logic              rdy1, rdy4;
    logic              put_one, put_word, take_one, take_word;
    logic              overrun, underrun;
    logic              raw_flag, ie_flag;
    logic [BYTE_W-1:0] head;
    logic [WW-1:0]     word_out;

    port_mode_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_wr  (reg_wr && reg_addr == OFF_CTRL),
        .cfg_en  (reg_wdata[0]),
        .cfg_dir (reg_wdata[1]),
        .cfg_dma (reg_wdata[2]),
        .state   (state),
        .dir_q   (dir_q),
        .dma_q   (dma_q),
        .flush   (flush)
    );

    assign in_rx = (state == ST_RX);
    assign in_tx = (state == ST_TX);
    assign free  = CW'(DEPTH) - level;

    always_comb begin
        rdy1 = 1'b0;
        rdy4 = 1'b0;
        if (in_rx) begin
            rdy1 = level >= CW'(1);
            rdy4 = level >= CW'(LANES);
        end else if (in_tx) begin
            rdy1 = free >= CW'(1);
            rdy4 = free >= CW'(LANES);
        end
    end

    assign take_word = reg_rd && reg_addr == OFF_DATA && in_rx && rdy4;
    assign put_word  = reg_wr && reg_addr == OFF_DATA && in_tx && rdy4;
    assign put_one   = port_push && in_rx && level != CW'(DEPTH);
    assign take_one  = port_pull && in_tx && level != '0;
    assign overrun   = port_push && in_rx && level == CW'(DEPTH);
    assign underrun  = port_pull && in_tx && level == '0;

    byte_ring #(.DEPTH(DEPTH), .BYTE_W(BYTE_W), .LANES(LANES)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .put_one   (put_one),
        .one_in    (port_din),
        .put_word  (put_word),
        .word_in   (reg_wdata),
        .take_one  (take_one),
        .take_word (take_word),
        .level     (level),
        .head      (head),
        .word_out  (word_out)
    );

    err_irq u_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .err_evt (overrun || underrun),
        .clr_req (reg_wr && reg_addr == OFF_CLR && reg_wdata[0]),
        .ie_wr   (reg_wr && reg_addr == OFF_IE),
        .ie_bit  (reg_wdata[0]),
        .raw     (raw_flag),
        .ie      (ie_flag),
        .irq     (irq)
    );

    assign port_dout = (in_tx && level != '0) ? head : '0;
    assign dma_req   = dma_q && rdy4;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFF_CTRL: begin
                reg_rdata[0] = (state != ST_OFF);
                reg_rdata[1] = dir_q;
                reg_rdata[2] = dma_q;
            end
            OFF_STAT: begin
                reg_rdata[0] = rdy1;
                reg_rdata[1] = rdy4;
            end
            OFF_RAW:  reg_rdata[0] = raw_flag;
            OFF_IE:   reg_rdata[0] = ie_flag;
            OFF_MIS:  reg_rdata[0] = irq;
            OFF_DATA: if (in_rx && rdy4) reg_rdata = word_out;
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/byte_word_fifo_props.sv
module byte_word_fifo_props
    import byte_word_fifo_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CW    = 4,
    parameter int WW    = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CW-1:0]     level,
    input logic              in_rx,
    input logic              in_tx,
    input logic              port_push,
    input logic              port_pull,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [WW-1:0]     reg_wdata,
    input logic              raw_flag,
    input logic              dma_req
);
    p_level_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CW'(DEPTH));

    p_off_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_rx || in_tx) |-> level == '0);

    p_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_rx || in_tx) && reg_wr && reg_addr == OFF_CTRL && !reg_wdata[0]
        |=> level == '0 && !in_rx && !in_tx);

    p_overrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_rx && port_push && level == CW'(DEPTH) |=> raw_flag);

    p_underrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_tx && port_pull && level == '0 |=> raw_flag);

    p_raw_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        raw_flag && !(reg_wr && reg_addr == OFF_CLR && reg_wdata[0]) |=> raw_flag);

    p_dma_enabled_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> (in_rx || in_tx));
endmodule

bind byte_word_fifo byte_word_fifo_props #(.DEPTH(DEPTH), .CW(CW), .WW(WW)) u_props (
    .clk       (clk),
    .rst_n     (rst_n),
    .level     (level),
    .in_rx     (in_rx),
    .in_tx     (in_tx),
    .port_push (port_push),
    .port_pull (port_pull),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .raw_flag  (raw_flag),
    .dma_req   (dma_req)
);

// File: tb/byte_word_fifo_test.sv
module byte_word_fifo_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        port_push = 1'b0, port_pull = 1'b0;
    logic [7:0]  port_din = '0;
    logic [7:0]  port_dout;
    logic        dma_req, irq;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    byte_word_fifo uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .port_push(port_push), .port_din(port_din), .port_pull(port_pull),
        .port_dout(port_dout), .dma_req(dma_req), .irq(irq)
    );

    localparam logic [1:0] W = 2'd0, R = 2'd1, P = 2'd2, L = 2'd3;
    localparam int NV = 64;
    // {req, op, offset, data, expected}
    localparam logic [77:0] VEC [NV] = '{
        {4'd10, W, 8'h0C, 32'h1, 32'h0},
        {4'd3,  W, 8'h00, 32'h5, 32'h0},
        {4'd3,  R, 8'h04, 32'h0, 32'h0},          // R3 empty
        {4'd3,  P, 8'h00, 32'h11, 32'h0},
        {4'd3,  R, 8'h04, 32'h0, 32'h1},          // R3 one byte
        {4'd3,  P, 8'h00, 32'h22, 32'h0},
        {4'd3,  P, 8'h00, 32'h33, 32'h0},
        {4'd3,  R, 8'h04, 32'h0, 32'h1},          // R3 three bytes
        {4'd13, R, 8'h28, 32'h0, 32'h0},          // R13 short read
        {4'd3,  P, 8'h00, 32'h44, 32'h0},
        {4'd3,  R, 8'h04, 32'h0, 32'h3},          // R3 four bytes
        {4'd2,  R, 8'h28, 32'h0, 32'h44332211},   // R2 packing
        {4'd3,  R, 8'h04, 32'h0, 32'h0},
        {4'd7,  P, 8'h00, 32'hA0, 32'h0},
        {4'd7,  P, 8'h00, 32'hA1, 32'h0},
        {4'd7,  P, 8'h00, 32'hA2, 32'h0},
        {4'd7,  P, 8'h00, 32'hA3, 32'h0},
        {4'd7,  P, 8'h00, 32'hA4, 32'h0},
        {4'd7,  P, 8'h00, 32'hA5, 32'h0},
        {4'd7,  P, 8'h00, 32'hA6, 32'h0},
        {4'd7,  P, 8'h00, 32'hA7, 32'h0},
        {4'd3,  R, 8'h04, 32'h0, 32'h3},          // R3 full
        {4'd7,  P, 8'h00, 32'hEE, 32'h0},         // R7 overrun
        {4'd7,  R, 8'h08, 32'h0, 32'h1},
        {4'd10, R, 8'h10, 32'h0, 32'h1},          // R10
        {4'd2,  R, 8'h28, 32'h0, 32'hA3A2A1A0},   // R2 wrapped
        {4'd7,  R, 8'h28, 32'h0, 32'hA7A6A5A4},   // R7 byte dropped
        {4'd3,  R, 8'h04, 32'h0, 32'h0},
        {4'd9,  W, 8'h14, 32'h0, 32'h0},
        {4'd9,  R, 8'h08, 32'h0, 32'h1},          // R9 write 0 no effect
        {4'd9,  W, 8'h14, 32'h1, 32'h0},
        {4'd9,  R, 8'h08, 32'h0, 32'h0},          // R9 cleared
        {4'd9,  R, 8'h14, 32'h0, 32'h0},
        {4'd12, W, 8'h00, 32'h3, 32'h0},
        {4'd12, R, 8'h00, 32'h0, 32'h5},          // R12
        {4'd6,  P, 8'h00, 32'h55, 32'h0},
        {4'd6,  W, 8'h00, 32'h0, 32'h0},
        {4'd6,  R, 8'h00, 32'h0, 32'h4},          // R6 off
        {4'd5,  R, 8'h04, 32'h0, 32'h0},          // R5
        {4'd6,  W, 8'h00, 32'h5, 32'h0},
        {4'd6,  R, 8'h04, 32'h0, 32'h0},          // R6 flushed
        {4'd13, R, 8'h18, 32'h0, 32'h0},          // R13 unmapped
        {4'd13, R, 8'h2C, 32'h0, 32'h0},
        {4'd4,  W, 8'h00, 32'h4, 32'h0},
        {4'd4,  W, 8'h00, 32'h7, 32'h0},
        {4'd4,  R, 8'h04, 32'h0, 32'h3},          // R4 all free
        {4'd2,  W, 8'h28, 32'hD4C3B2A1, 32'h0},
        {4'd4,  R, 8'h04, 32'h0, 32'h3},
        {4'd2,  W, 8'h28, 32'h08070605, 32'h0},
        {4'd4,  R, 8'h04, 32'h0, 32'h0},          // R4 none free
        {4'd13, W, 8'h28, 32'hFFFFFFFF, 32'h0},   // R13 ignored write
        {4'd2,  L, 8'h00, 32'h0, 32'hA1},         // R2 byte 0 first
        {4'd4,  R, 8'h04, 32'h0, 32'h1},
        {4'd2,  L, 8'h00, 32'h0, 32'hB2},
        {4'd2,  L, 8'h00, 32'h0, 32'hC3},
        {4'd2,  L, 8'h00, 32'h0, 32'hD4},
        {4'd4,  R, 8'h04, 32'h0, 32'h3},
        {4'd2,  L, 8'h00, 32'h0, 32'h05},
        {4'd2,  L, 8'h00, 32'h0, 32'h06},
        {4'd2,  L, 8'h00, 32'h0, 32'h07},
        {4'd13, L, 8'h00, 32'h0, 32'h08},         // R13 no FF bytes
        {4'd8,  L, 8'h00, 32'h0, 32'h00},         // R8 underrun
        {4'd8,  R, 8'h08, 32'h0, 32'h1},
        {4'd10, R, 8'h10, 32'h0, 32'h1}
    };

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic op(input logic [1:0] k, input logic [7:0] a, input logic [31:0] d,
                      input logic [31:0] e, input int req);
        @(negedge clk);
        reg_addr = a;
        case (k)
            W: begin reg_wr = 1'b1; reg_wdata = d; end
            R: reg_rd = 1'b1;
            P: begin port_push = 1'b1; port_din = d[7:0]; end
            default: port_pull = 1'b1;
        endcase
        #1;
        if (k == R) check(req, reg_rdata, e);
        if (k == L) check(req, {24'b0, port_dout}, e);
        @(posedge clk);
        #1;
        reg_wr = 1'b0; reg_rd = 1'b0; port_push = 1'b0; port_pull = 1'b0;
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog (all requirements) actual timeout expected completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        op(R, 8'h00, 0, 32'h4, 1);
        op(R, 8'h04, 0, 32'h0, 1);
        op(R, 8'h08, 0, 32'h0, 1);
        op(R, 8'h0C, 0, 32'h0, 1);
        op(R, 8'h10, 0, 32'h0, 1);
        check(1, {30'b0, irq, dma_req}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            op(VEC[i][73:72], VEC[i][71:64], VEC[i][63:32], VEC[i][31:0], int'(VEC[i][77:74]));
        end

        // R10 / R11: transmit, empty, error set, enable set
        @(negedge clk); #1;
        check(10, {31'b0, irq}, 32'h1);
        check(11, {31'b0, dma_req}, 32'h1);
        op(W, 8'h0C, 32'h0, 0, 10);
        @(negedge clk); #1;
        check(10, {31'b0, irq}, 32'h0);
        op(R, 8'h10, 0, 32'h0, 10);
        op(R, 8'h08, 0, 32'h1, 10);

        // R5: disabled port activity ignored
        op(W, 8'h00, 32'h0, 0, 11);
        @(negedge clk); #1;
        check(11, {31'b0, dma_req}, 32'h0);
        op(W, 8'h14, 32'h1, 0, 5);
        for (int i = 0; i < 10; i++) op(P, 8'h00, 32'hC0 + i, 0, 5);
        op(L, 8'h00, 0, 32'h0, 5);
        op(R, 8'h08, 0, 32'h0, 5);
        op(R, 8'h04, 0, 32'h0, 5);

        // R11: receive without DMA
        op(W, 8'h00, 32'h1, 0, 11);
        for (int i = 0; i < 4; i++) op(P, 8'h00, 32'h60 + i, 0, 11);
        op(R, 8'h04, 0, 32'h3, 11);
        @(negedge clk); #1;
        check(11, {31'b0, dma_req}, 32'h0);
        op(R, 8'h28, 0, 32'h63626160, 5);

        // R11: receive with DMA
        op(W, 8'h00, 32'h0, 0, 11);
        op(W, 8'h00, 32'h5, 0, 11);
        for (int i = 0; i < 3; i++) op(P, 8'h00, 32'h70 + i, 0, 11);
        @(negedge clk); #1;
        check(11, {31'b0, dma_req}, 32'h0);
        op(P, 8'h00, 32'h73, 0, 11);
        @(negedge clk); #1;
        check(11, {31'b0, dma_req}, 32'h1);

        report();
    end
endmodule